// File: doc/BRIEF.md
# Focus Search and Capture Controller

This block drives the focus actuator of an optical pickup while the servo hunts for the in-focus point. After a start command it sweeps the lens with a triangular ramp between two programmable limits. The step size is programmable too. While the sweep runs it asserts a spindle kick enable, so the disc turns during the search. It watches a digitized focus error sample and a focus-OK flag, and it hands the loop to the focus equalizer once three conditions hold in the same cycle. First, the lens must be moving toward the disc. Second, focus-OK must be high. Third, a zero-cross flag must have been latched after the focus error rose through a programmable threshold.

Once the loop is closed the controller freezes the drive value and raises the loop-closed select. It pulls its active-low focus-closed indication low and starts a timer. When the timer expires it opens a window output, which tells the supervising controller that it may start to judge focus-OK and, if that flag is low, begin protection.

If the lens is not captured within a programmable number of complete ramp periods, the sweep stops, the drive is parked at zero and a fail flag is raised. A new start command restarts the search from the failed state or from the closed state.

Top module: `focus_acq`

## Requirements
- R1: While reset is high and afterwards until a start is accepted, drive_o is 0, kick_o, loop_closed_o, check_win_o and fail_o are 0, and focus_closed_n_o is 1.
- R2: A start_i seen at a clock edge while the controller is not searching begins a search at that edge. From then on kick_o is 1 and drive_o equals lo_lim_i, moving up. A start_i seen during a search has no effect.
- R3: During a search, every clock edge moves drive_o by step_i. Upward (toward the disc) the value is clamped to hi_lim_i and the direction turns down when the new value would reach or pass it. Downward the value is clamped to lo_lim_i and the direction turns up under the same rule.
- R4: The zero-cross flag is set one edge after a sample where fe_i >= fz_thr_i follows a sample below it. The flag is cleared at every direction change and at start. A focus error that is already at or above the threshold at start does not set it.
- R5: At an edge where the search is moving up, fok_i is 1 and the zero-cross flag is set, the controller closes. From that edge on, focus_closed_n_o is 0, loop_closed_o is 1, kick_o is 0, and drive_o keeps the value it had.
- R6: No capture happens while the ramp moves down or while fok_i is 0, whatever the zero-cross flag holds.
- R7: check_win_o goes to 1 exactly WIN_CYCLES edges after the capture edge. It stays 1 while closed and is 0 in every other state.
- R8: Each reversal at the lower limit completes one ramp period. When the completed count reaches max_per_i (non-zero), the controller enters the failed state at that edge, with fail_o 1, drive_o 0 and kick_o 0. A max_per_i of 0 lets the search run without a limit.
- R9: A start_i seen while closed or failed restarts the search exactly as in R2, and clears fail_o, loop_closed_o and check_win_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start search command |
| fok_i | input | 1 | Focus-OK flag from the RF level detector |
| fe_i | input | FE_W | Signed focus error sample |
| fz_thr_i | input | FE_W | Signed zero-cross threshold |
| step_i | input | DRV_W | Unsigned ramp step per clock |
| lo_lim_i | input | DRV_W | Signed lower ramp limit (far from disc) |
| hi_lim_i | input | DRV_W | Signed upper ramp limit (near the disc) |
| max_per_i | input | PER_W | Ramp periods allowed before failing, 0 = unlimited |
| drive_o | output | DRV_W | Signed actuator drive value |
| kick_o | output | 1 | Spindle kick enable, high while searching |
| loop_closed_o | output | 1 | Hands the actuator to the focus equalizer |
| focus_closed_n_o | output | 1 | Low while focus is closed |
| check_win_o | output | 1 | Focus-OK judgement window open |
| fail_o | output | 1 | Search gave up |

## Verification
The hardest situation to reach is a capture that is correctly refused. This covers a threshold crossing during the downward half of the sweep, focus-OK that is high only while the lens retreats, and a focus error that sits above the threshold from the first sample. The bench builds each of these with directed phases that drive fok_i and fe_i from the expected lens position and direction. It then adds random episodes, in which the focus error follows the distance from a random focus point plus noise, so that legal captures, reversals and period exhaustion occur in many combinations. A cycle-level reference model in the bench predicts every output at every cycle.

// File: rtl/focus_acq_pkg.sv
package focus_acq_pkg;

    localparam int PER_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SEARCH = 2'd1,
        ST_CLOSED = 2'd2,
        ST_FAILED = 2'd3
    } acq_state_e;

    typedef enum logic [1:0] {
        RC_PARK = 2'd0,
        RC_LOAD = 2'd1,
        RC_STEP = 2'd2,
        RC_HOLD = 2'd3
    } ramp_cmd_e;

    typedef struct packed {
        logic rev_top;
        logic rev_bot;
    } ramp_evt_t;

    // true when one more completed period reaches a non-zero limit
    function automatic logic periods_exhausted(input logic [PER_W-1:0] done,
                                               input logic [PER_W-1:0] limit);
        logic [PER_W:0] nxt;
        nxt = {1'b0, done} + {{PER_W{1'b0}}, 1'b1};
        return (limit != '0) && (nxt >= {1'b0, limit});
    endfunction

    function automatic logic [PER_W-1:0] sat_inc(input logic [PER_W-1:0] v);
        return (v == '1) ? v : v + 1'b1;
    endfunction

endpackage

// File: rtl/focus_acq_ramp.sv
module focus_acq_ramp
    import focus_acq_pkg::*;
#(
    parameter int DRV_W = 12
) (
    input  logic                    clk,
    input  logic                    rst,
    input  ramp_cmd_e               cmd,
    input  logic        [DRV_W-1:0] step_i,
    input  logic signed [DRV_W-1:0] lo_i,
    input  logic signed [DRV_W-1:0] hi_i,
    output logic signed [DRV_W-1:0] drive_o,
    output logic                    up_o,
    output ramp_evt_t               evt_o
);
    localparam int EXT_W = DRV_W + 2;

    logic signed [EXT_W-1:0] cur_x, lo_x, hi_x, step_x, nxt_up, nxt_dn;

    always_comb begin
        cur_x  = {{2{drive_o[DRV_W-1]}}, drive_o};
        lo_x   = {{2{lo_i[DRV_W-1]}}, lo_i};
        hi_x   = {{2{hi_i[DRV_W-1]}}, hi_i};
        step_x = {2'b00, step_i};
        nxt_up = cur_x + step_x;
        nxt_dn = cur_x - step_x;
        evt_o.rev_top = up_o && (nxt_up >= hi_x);
        evt_o.rev_bot = !up_o && (nxt_dn <= lo_x);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            drive_o <= '0;
            up_o    <= 1'b1;
        end else begin
            unique case (cmd)
                RC_PARK: begin
                    drive_o <= '0;
                    up_o    <= 1'b1;
                end
                RC_LOAD: begin
                    drive_o <= lo_i;
                    up_o    <= 1'b1;
                end
                RC_STEP: begin
                    if (up_o) begin
                        if (evt_o.rev_top) begin
                            drive_o <= hi_i;
                            up_o    <= 1'b0;
                        end else begin
                            drive_o <= nxt_up[DRV_W-1:0];
                        end
                    end else begin
                        if (evt_o.rev_bot) begin
                            drive_o <= lo_i;
                            up_o    <= 1'b1;
                        end else begin
                            drive_o <= nxt_dn[DRV_W-1:0];
                        end
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/focus_acq_zc.sv
module focus_acq_zc #(
    parameter int FE_W = 10
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   arm,
    input  logic                   run,
    input  logic                   clr,
    input  logic signed [FE_W-1:0] fe_i,
    input  logic signed [FE_W-1:0] thr_i,
    output logic                   zc_o
);
    logic above, above_q;

    assign above = (fe_i >= thr_i);

    always_ff @(posedge clk) begin
        if (rst || arm) begin
            above_q <= 1'b1;
            zc_o    <= 1'b0;
        end else if (run) begin
            above_q <= above;
            if (clr)
                zc_o <= 1'b0;
            else if (!above_q && above)
                zc_o <= 1'b1;
        end
    end

endmodule

// File: rtl/focus_acq_win.sv
module focus_acq_win #(
    parameter int WIN_CYCLES = 2000
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic open_o
);
    localparam int CW = $clog2(WIN_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(WIN_CYCLES);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !en)
            cnt_q <= '0;
        else if (cnt_q != LIMIT)
            cnt_q <= cnt_q + 1'b1;
    end

    assign open_o = en && (cnt_q == LIMIT);

endmodule

// File: rtl/focus_acq.sv
module focus_acq
    import focus_acq_pkg::*;
#(
    parameter int DRV_W      = 12,
    parameter int FE_W       = 10,
    parameter int WIN_CYCLES = 2000
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start_i,
    input  logic                    fok_i,
    input  logic signed [FE_W-1:0]  fe_i,
    input  logic signed [FE_W-1:0]  fz_thr_i,
    input  logic        [DRV_W-1:0] step_i,
    input  logic signed [DRV_W-1:0] lo_lim_i,
    input  logic signed [DRV_W-1:0] hi_lim_i,
    input  logic        [PER_W-1:0] max_per_i,
    output logic signed [DRV_W-1:0] drive_o,
    output logic                    kick_o,
    output logic                    loop_closed_o,
    output logic                    focus_closed_n_o,
    output logic                    check_win_o,
    output logic                    fail_o
);
    acq_state_e       state_q, state_d;
    ramp_cmd_e        rcmd;
    ramp_evt_t        revt;
    logic             ramp_up;
    logic             zc_q;
    logic [PER_W-1:0] per_q;
    logic             searching, start_ok, capture, fail_now, win_open;

    assign searching = (state_q == ST_SEARCH);
    assign start_ok  = start_i && !searching;
    assign capture   = searching && ramp_up && fok_i && zc_q;
    assign fail_now  = searching && !capture && revt.rev_bot
                       && periods_exhausted(per_q, max_per_i);

    always_comb begin
        state_d = state_q;
        rcmd    = RC_HOLD;
        if (start_ok) begin
            state_d = ST_SEARCH;
            rcmd    = RC_LOAD;
        end else begin
            unique case (state_q)
                ST_SEARCH: begin
                    if (capture) begin
                        state_d = ST_CLOSED;
                        rcmd    = RC_HOLD;
                    end else if (fail_now) begin
                        state_d = ST_FAILED;
                        rcmd    = RC_PARK;
                    end else begin
                        rcmd    = RC_STEP;
                    end
                end
                ST_CLOSED: rcmd = RC_HOLD;
                default:   rcmd = RC_PARK;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            per_q   <= '0;
        end else begin
            state_q <= state_d;
            if (start_ok)
                per_q <= '0;
            else if (rcmd == RC_STEP && revt.rev_bot)
                per_q <= sat_inc(per_q);
        end
    end

    focus_acq_ramp #(.DRV_W(DRV_W)) u_ramp (
        .clk     (clk),
        .rst     (rst),
        .cmd     (rcmd),
        .step_i  (step_i),
        .lo_i    (lo_lim_i),
        .hi_i    (hi_lim_i),
        .drive_o (drive_o),
        .up_o    (ramp_up),
        .evt_o   (revt)
    );

    focus_acq_zc #(.FE_W(FE_W)) u_zc (
        .clk   (clk),
        .rst   (rst),
        .arm   (start_ok),
        .run   (searching),
        .clr   (revt.rev_top | revt.rev_bot),
        .fe_i  (fe_i),
        .thr_i (fz_thr_i),
        .zc_o  (zc_q)
    );

    focus_acq_win #(.WIN_CYCLES(WIN_CYCLES)) u_win (
        .clk    (clk),
        .rst    (rst),
        .en     (state_q == ST_CLOSED),
        .open_o (win_open)
    );

    assign kick_o           = searching;
    assign loop_closed_o    = (state_q == ST_CLOSED);
    assign focus_closed_n_o = (state_q != ST_CLOSED);
    assign check_win_o      = win_open;
    assign fail_o           = (state_q == ST_FAILED);

endmodule

// File: rtl/focus_acq_chk.sv
module focus_acq_chk #(
    parameter int DRV_W = 12
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    fok_i,
    input logic                    dir_up,
    input logic signed [DRV_W-1:0] drive_o,
    input logic                    kick_o,
    input logic                    loop_closed_o,
    input logic                    focus_closed_n_o,
    input logic                    check_win_o,
    input logic                    fail_o
);
    // R1: at most one operating state flag at a time
    a_r1_one_state: assert property (@(posedge clk) disable iff (rst)
        $onehot0({kick_o, loop_closed_o, fail_o}));

    // R5: closing needs focus-OK in the capture cycle
    a_r5_close_needs_fok: assert property (@(posedge clk) disable iff (rst)
        $fell(focus_closed_n_o) |-> $past(fok_i));

    // R6: closing only from a search moving toward the disc
    a_r6_close_moving_up: assert property (@(posedge clk) disable iff (rst)
        $fell(focus_closed_n_o) |-> ($past(kick_o) && $past(dir_up)));

    // R5: drive frozen while the loop stays closed
    a_r5_drive_frozen: assert property (@(posedge clk) disable iff (rst)
        (loop_closed_o && $past(loop_closed_o)) |-> $stable(drive_o));

    // R7: window only inside the closed state
    a_r7_win_in_closed: assert property (@(posedge clk) disable iff (rst)
        check_win_o |-> (loop_closed_o && !focus_closed_n_o));

    // R8: failed state is parked and quiet
    a_r8_fail_parked: assert property (@(posedge clk) disable iff (rst)
        fail_o |-> (drive_o == '0 && !kick_o));

endmodule

bind focus_acq focus_acq_chk #(.DRV_W(DRV_W)) u_chk (
    .clk              (clk),
    .rst              (rst),
    .fok_i            (fok_i),
    .dir_up           (ramp_up),
    .drive_o          (drive_o),
    .kick_o           (kick_o),
    .loop_closed_o    (loop_closed_o),
    .focus_closed_n_o (focus_closed_n_o),
    .check_win_o      (check_win_o),
    .fail_o           (fail_o)
);

// File: tb/focus_acq_tb_top.sv
module focus_acq_tb_top;
    localparam int DRV_W = 12;
    localparam int FE_W  = 10;
    localparam int WIN   = 2000;
    localparam int S_IDLE = 0, S_SRCH = 1, S_CLSD = 2, S_FAIL = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0;
    logic fok_i = 1'b0;
    logic signed [FE_W-1:0]  fe_i = '0;
    logic signed [FE_W-1:0]  fz_thr_i = '0;
    logic        [DRV_W-1:0] step_i = 12'd100;
    logic signed [DRV_W-1:0] lo_lim_i = -12'sd800;
    logic signed [DRV_W-1:0] hi_lim_i = 12'sd800;
    logic        [7:0]       max_per_i = 8'd0;
    logic signed [DRV_W-1:0] drive_o;
    logic kick_o, loop_closed_o, focus_closed_n_o, check_win_o, fail_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    // reference model state
    int m_st, m_drive, m_per, m_win;
    bit m_up, m_cmpq, m_zc;

    always #2 clk = ~clk;

    focus_acq #(.DRV_W(DRV_W), .FE_W(FE_W), .WIN_CYCLES(WIN)) dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .fok_i(fok_i), .fe_i(fe_i),
        .fz_thr_i(fz_thr_i), .step_i(step_i), .lo_lim_i(lo_lim_i),
        .hi_lim_i(hi_lim_i), .max_per_i(max_per_i), .drive_o(drive_o),
        .kick_o(kick_o), .loop_closed_o(loop_closed_o),
        .focus_closed_n_o(focus_closed_n_o), .check_win_o(check_win_o),
        .fail_o(fail_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_st = S_IDLE; m_drive = 0; m_per = 0; m_win = 0;
        m_up = 1; m_cmpq = 1; m_zc = 0;
    endtask

    // next state from requirements, using inputs the DUT samples at the coming edge
    task automatic model_step();
        int n, lo, hi, st;
        bit rt, rb, cmp;
        lo = int'(lo_lim_i); hi = int'(hi_lim_i); st = int'(step_i);
        cmp = (int'(fe_i) >= int'(fz_thr_i));
        if (start_i && m_st != S_SRCH) begin
            m_st = S_SRCH; m_drive = lo; m_up = 1; m_cmpq = 1; m_zc = 0; m_per = 0;
        end else if (m_st == S_SRCH) begin
            if (m_up && fok_i && m_zc) begin
                m_st = S_CLSD; m_win = 0;
            end else begin
                rt = 0; rb = 0;
                if (m_up) begin
                    n = m_drive + st;
                    if (n >= hi) begin m_drive = hi; m_up = 0; rt = 1; end
                    else m_drive = n;
                end else begin
                    n = m_drive - st;
                    if (n <= lo) begin m_drive = lo; m_up = 1; rb = 1; end
                    else m_drive = n;
                end
                if (rt || rb) m_zc = 0;
                else if (!m_cmpq && cmp) m_zc = 1;
                m_cmpq = cmp;
                if (rb) begin
                    if (max_per_i != 0 && m_per + 1 >= int'(max_per_i)) begin
                        m_st = S_FAIL; m_drive = 0;
                    end
                    if (m_per < 255) m_per++;
                end
            end
        end else if (m_st == S_CLSD) begin
            if (m_win < WIN) m_win++;
        end else begin
            m_drive = 0;
        end
    endtask

    task automatic compare_all();
        chk(int'(drive_o) == m_drive, "R3 drive", int'(drive_o), m_drive);
        chk(kick_o == (m_st == S_SRCH), "R2 kick", kick_o, m_st == S_SRCH);
        chk(loop_closed_o == (m_st == S_CLSD), "R5 loop_closed", loop_closed_o, m_st == S_CLSD);
        chk(focus_closed_n_o == (m_st != S_CLSD), "R5 focus_closed_n", focus_closed_n_o, m_st != S_CLSD);
        chk(check_win_o == (m_st == S_CLSD && m_win == WIN), "R7 window", check_win_o,
            m_st == S_CLSD && m_win == WIN);
        chk(fail_o == (m_st == S_FAIL), "R8 fail", fail_o, m_st == S_FAIL);
    endtask

    task automatic tick();
        model_step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic do_start();
        start_i = 1'b1; tick(); start_i = 1'b0;
    endtask

    // focus error follows distance from a focus point, with noise
    task automatic drive_fe(input int fpt, input int noise, input int fwin, input bit fok_en);
        int d;
        d = m_drive - fpt + ((noise > 0) ? ($urandom_range(0, 2 * noise) - noise) : 0);
        if (d > 511) d = 511;
        if (d < -512) d = -512;
        fe_i = FE_W'(d);
        fok_i = fok_en && (m_drive - fpt > -fwin) && (m_drive - fpt < fwin);
    endtask

    initial begin : watchdog
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++;
                $display("FAIL watchdog expired after %0d cycles", cycles);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin : stim
        bit seen;
        void'($urandom(32'h5eed_f0c5));
        model_reset();
        repeat (3) @(negedge clk);
        // R1 reset state
        compare_all();
        rst = 1'b0;
        repeat (4) tick();
        chk(focus_closed_n_o == 1'b1 && kick_o == 1'b0, "R1 idle after reset", focus_closed_n_o, 1);

        // R2 start and R3 ramp: fok low, unlimited periods
        max_per_i = 8'd0; fz_thr_i = '0;
        do_start();
        chk(int'(drive_o) == -800 && kick_o, "R2 start loads lower limit", int'(drive_o), -800);
        repeat (40) begin drive_fe(0, 0, 50, 0); tick(); end
        // R2 start ignored during search
        start_i = 1'b1; tick(); start_i = 1'b0;
        chk(kick_o == 1'b1, "R2 start ignored while searching", kick_o, 1);
        repeat (200) begin drive_fe(0, 0, 50, 0); tick(); end
        chk(fail_o == 1'b0, "R8 zero limit never fails", fail_o, 0);

        // R4 focus error above threshold from the start never latches
        rst = 1'b1; model_reset(); @(negedge clk); rst = 1'b0;
        fz_thr_i = -10'sd100; fe_i = 10'sd200; fok_i = 1'b1;
        do_start();
        repeat (150) tick();
        chk(focus_closed_n_o == 1'b1, "R4 no crossing no capture", focus_closed_n_o, 1);

        // R6 focus-OK only while moving down
        rst = 1'b1; model_reset(); @(negedge clk); rst = 1'b0;
        fz_thr_i = '0;
        do_start();
        seen = 0;
        repeat (200) begin
            drive_fe(0, 0, 2000, 1);
            if (m_up) fok_i = 1'b0;
            tick();
            if (!focus_closed_n_o) seen = 1;
        end
        chk(seen == 0, "R6 no capture moving away", seen, 0);

        // R5 legal capture, R7 window timing, R9 restart from closed
        fz_thr_i = '0;
        do_start();
        repeat (100) begin
            if (m_st == S_SRCH) drive_fe(130, 0, 200, 1);
            tick();
        end
        chk(loop_closed_o == 1'b1, "R5 capture with all conditions", loop_closed_o, 1);
        fok_i = 1'b0;
        repeat (WIN + 5) tick();
        chk(check_win_o == 1'b1, "R7 window open after delay", check_win_o, 1);
        do_start();
        chk(kick_o && !check_win_o && !loop_closed_o, "R9 restart from closed", kick_o, 1);

        // R8 period limit then R9 restart from failed
        max_per_i = 8'd2; fok_i = 1'b0;
        repeat (80) begin drive_fe(0, 0, 50, 0); tick(); end
        chk(fail_o == 1'b1 && int'(drive_o) == 0, "R8 period limit fails", fail_o, 1);
        do_start();
        chk(fail_o == 1'b0 && kick_o, "R9 restart from failed", fail_o, 0);

        // random episodes
        for (int ep = 0; ep < 40; ep++) begin
            int lo, hi, fpt, noise, fw, len;
            bit fen;
            lo = -int'($urandom_range(100, 1500));
            hi = int'($urandom_range(100, 1500));
            step_i = DRV_W'($urandom_range(5, 180));
            lo_lim_i = DRV_W'(lo); hi_lim_i = DRV_W'(hi);
            fz_thr_i = FE_W'(int'($urandom_range(0, 120)) - 60);
            max_per_i = 8'($urandom_range(0, 4));
            fpt = int'($urandom_range(0, hi - lo)) + lo;
            noise = int'($urandom_range(0, 40));
            fw = int'($urandom_range(20, 300));
            fen = ($urandom_range(0, 3) != 0);
            len = int'($urandom_range(100, 600));
            do_start();
            for (int c = 0; c < len; c++) begin
                drive_fe(fpt, noise, fw, fen);
                if ($urandom_range(0, 7) == 0) fok_i = ~fok_i;
                if ($urandom_range(0, 150) == 0) start_i = 1'b1;
                tick();
                start_i = 1'b0;
            end
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule